// File: doc/BRIEF.md
# Configurable UART Transmit Channel

This block is the transmit half of an asynchronous serial port. Software places bytes in a small FIFO through a data write port. A frame sequencer takes the bytes out one at a time and sends each one on a single output line. Every frame is shaped by a mode word. The mode word selects a character length of 6, 7 or 8 bits, a parity bit that is even, odd or absent, and a stop period of one, one and a half or two bit times.

Bit timing comes from an external oversampling strobe, `tick`. A fixed number of ticks (`OVS`) makes up one bit period. The sequencer advances only on cycles where the strobe is high.

Software controls the channel through a control word. One bit enables the channel, and another bit resets the transmit logic and clears itself. A status word reports three conditions: FIFO full, FIFO empty, and a busy flag that stays high until the last stop period has been sent. The mode word is sampled when a frame begins, so a change to it takes effect from the next frame.

Top module: `uart_tx_channel`

## Requirements
- R1: After `rst`, the line is high, `status_o` equals 12'h008 (only the empty bit is set) and `ctrl_q` is zero.
- R2: The line idles high. A frame begins with a low start bit lasting `OVS` ticks, followed by the data bits, least significant bit first, each lasting `OVS` ticks.
- R3: Mode bits [2:1] choose the character length: 00 or 01 sends 8 bits, 10 sends 7 bits and 11 sends 6 bits. The bits above the chosen length are not sent.
- R4: Mode bit 5 set means no parity bit is sent. With bit 5 clear, a parity bit of `OVS` ticks follows the data bits: mode bit 3 = 0 gives even parity and mode bit 3 = 1 gives odd parity. Mode bit 4 has no effect.
- R5: Mode bits [7:6] choose the stop period: 00 is `OVS` ticks, 01 is `OVS + OVS/2` ticks, and 10 or 11 is `2*OVS` ticks. When frames are queued back to back, the line stays high for the stop period plus exactly one clock before the next start bit.
- R6: Status bit 4 is high when the FIFO holds `FIFO_DEPTH` bytes, and status bit 3 is high when it holds none. A data write while the FIFO is full is dropped.
- R7: Status bit 11 is high from the start bit to the end of the stop period. It can be high while status bit 3 shows an empty FIFO.
- R8: While control bit 4 (enable) is clear, no new frame begins and queued bytes stay in the FIFO.
- R9: Writing control bit 1 (logic reset) empties the FIFO, stops any frame in progress and returns the line high. The bit reads back as set for one cycle after the write and as clear from the cycle after that.
- R10: On a cycle with `tick` low, a frame in progress does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling strobe from the baud generator |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_din | input | 5 | Control word: bit 4 enable, bit 1 logic reset |
| mode_wr | input | 1 | Mode word write strobe |
| mode_din | input | 8 | Mode word: length [2:1], parity [5:3], stop [7:6] |
| data_wr | input | 1 | Data write strobe (pushes one byte) |
| data_din | input | 8 | Byte to queue |
| txd | output | 1 | Serial output line |
| status_o | output | 12 | Status word: bit 11 busy, bit 4 full, bit 3 empty |
| ctrl_q | output | 5 | Control word read-back |

## Verification
The frame format is swept over all 64 mode-word combinations: every value of the length field, four parity codes (even, odd, none, and even with the unused bit 4 set) and every value of the stop field. Each combination sends a pair of back-to-back bytes, so a wrong length, a wrong parity bit or a stop period that is off by one tick shows up as a bad data, parity or gap count. The two bytes of each pair are bitwise complements, so a stuck data bit or an inverted bit order is also caught.

Separate sequences cover the following:
- overfilling the FIFO while the channel is disabled, then draining it;
- the busy flag with an empty FIFO;
- withholding the enable;
- a logic reset while the FIFO holds bytes, and another while a frame is in flight;
- stalling the tick during a start bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W = 8;
    localparam int MODE_W = 8;
    localparam int CTRL_W = 5;
    localparam int STAT_W = 12;

    // status and control bit positions
    localparam int ST_BUSY  = 11;
    localparam int ST_FULL  = 4;
    localparam int ST_EMPTY = 3;
    localparam int CT_EN    = 4;
    localparam int CT_RST   = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } tx_state_e;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop_sel;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        frame_cfg_t c;
        case (m[2:1])
            2'b10:   c.nbits = 4'd7;
            2'b11:   c.nbits = 4'd6;
            default: c.nbits = 4'd8;
        endcase
        c.par_en   = ~m[5];
        c.par_odd  = m[3];
        c.stop_sel = m[7:6];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] char_mask(input logic [3:0] n);
        logic [15:0] ones;
        ones = (16'd1 << n) - 16'd1;
        return ones[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [DW-1:0]   mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CNTW-1:0] count;
    logic            do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNTW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              enable,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] head,
    input  logic [MODE_W-1:0] mode,
    output logic              pop,
    output logic              txd,
    output logic              busy
);
    localparam int CW = $clog2(2 * OVS + 1);
    localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
    localparam logic [CW-1:0] STOP_ONE  = CW'(OVS - 1);
    localparam logic [CW-1:0] STOP_HALF = CW'(OVS + OVS / 2 - 1);
    localparam logic [CW-1:0] STOP_TWO  = CW'(2 * OVS - 1);

    tx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     limit;
    logic [DATA_W-1:0] sh;
    logic [3:0]        bidx;
    logic              par_bit;
    frame_cfg_t        cfg;
    frame_cfg_t        new_cfg;
    logic              go;

    assign new_cfg = decode_mode(mode);
    assign go      = (state == S_IDLE) && enable && !fifo_empty;
    assign pop     = go;
    assign busy    = (state != S_IDLE);

    always_comb begin
        if (state == S_STOP) begin
            case (cfg.stop_sel)
                2'b00:   limit = STOP_ONE;
                2'b01:   limit = STOP_HALF;
                default: limit = STOP_TWO;
            endcase
        end else begin
            limit = BIT_LAST;
        end
    end

    always_comb begin
        case (state)
            S_START: txd = 1'b0;
            S_DATA:  txd = sh[0];
            S_PAR:   txd = par_bit;
            default: txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cnt     <= '0;
            sh      <= '0;
            bidx    <= '0;
            par_bit <= 1'b0;
            cfg     <= '0;
        end else if (state == S_IDLE) begin
            if (go) begin
                state   <= S_START;
                cnt     <= '0;
                bidx    <= '0;
                sh      <= head;
                cfg     <= new_cfg;
                par_bit <= (^(head & char_mask(new_cfg.nbits))) ^ new_cfg.par_odd;
            end
        end else if (tick) begin
            if (cnt == limit) begin
                cnt <= '0;
                case (state)
                    S_START: state <= S_DATA;
                    S_DATA: begin
                        sh   <= sh >> 1;
                        bidx <= bidx + 1'b1;
                        if (bidx == cfg.nbits - 4'd1)
                            state <= cfg.par_en ? S_PAR : S_STOP;
                    end
                    S_PAR:   state <= S_STOP;
                    default: state <= S_IDLE;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_tx_channel.sv
module uart_tx_channel
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_din,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_din,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_din,
    output logic              txd,
    output logic [STAT_W-1:0] status_o,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic              en_q;
    logic              srst_q;
    logic              logic_rst;
    logic [MODE_W-1:0] mode_q;
    logic [DATA_W-1:0] head;
    logic              fifo_empty, fifo_full, pop, busy;

    assign logic_rst = rst | srst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            srst_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q   <= ctrl_din[CT_EN];
            srst_q <= ctrl_din[CT_RST];
        end else begin
            srst_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= '0;
        else if (mode_wr) mode_q <= mode_din;
    end

    uart_tx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .DW    (DATA_W)
    ) u_fifo (
        .clk   (clk),
        .rst   (logic_rst),
        .push  (data_wr),
        .pop   (pop),
        .din   (data_din),
        .head  (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    uart_tx_shifter #(
        .OVS (OVS)
    ) u_shift (
        .clk        (clk),
        .rst        (logic_rst),
        .tick       (tick),
        .enable     (en_q),
        .fifo_empty (fifo_empty),
        .head       (head),
        .mode       (mode_q),
        .pop        (pop),
        .txd        (txd),
        .busy       (busy)
    );

    always_comb begin
        status_o           = '0;
        status_o[ST_BUSY]  = busy;
        status_o[ST_FULL]  = fifo_full;
        status_o[ST_EMPTY] = fifo_empty;
        ctrl_q             = '0;
        ctrl_q[CT_EN]      = en_q;
        ctrl_q[CT_RST]     = srst_q;
    end

endmodule

// File: rtl/uart_tx_channel_chk.sv
module uart_tx_channel_chk
    import uart_tx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              data_wr,
    input logic              txd,
    input logic [STAT_W-1:0] status_o,
    input logic [CTRL_W-1:0] ctrl_q
);
    assert_idle_line_high_R2: assert property (@(posedge clk) disable iff (rst)
        !status_o[ST_BUSY] |-> txd);

    assert_full_not_empty_R6: assert property (@(posedge clk) disable iff (rst)
        !(status_o[ST_FULL] && status_o[ST_EMPTY]));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (status_o[ST_FULL] && data_wr && !ctrl_q[CT_EN] && !ctrl_q[CT_RST])
        |=> status_o[ST_FULL]);

    assert_disabled_stays_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[CT_EN] && !status_o[ST_BUSY]) |=> !status_o[ST_BUSY]);

    assert_soft_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[CT_RST] |=> (status_o[ST_EMPTY] && !status_o[ST_BUSY] && txd));

    assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick && status_o[ST_BUSY] && !ctrl_q[CT_RST]) |=> $stable(txd));

endmodule

bind uart_tx_channel uart_tx_channel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .data_wr  (data_wr),
    .txd      (txd),
    .status_o (status_o),
    .ctrl_q   (ctrl_q)
);

// File: tb/uart_tx_channel_test.sv
`timescale 1ns/1ps
module uart_tx_channel_test;
    localparam int DEPTH = 4;
    localparam int OVS   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic [4:0] ctrl_din = '0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_din = '0;
    logic       data_wr = 1'b0;
    logic [7:0] data_din = '0;
    logic       txd;
    logic [11:0] status_o;
    logic [4:0]  ctrl_q;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;

    uart_tx_channel #(.FIFO_DEPTH(DEPTH), .OVS(OVS)) uut (
        .clk(clk), .rst(rst), .tick(tick),
        .ctrl_wr(ctrl_wr), .ctrl_din(ctrl_din),
        .mode_wr(mode_wr), .mode_din(mode_din),
        .data_wr(data_wr), .data_din(data_din),
        .txd(txd), .status_o(status_o), .ctrl_q(ctrl_q)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input bit en, input bit rs);
        ctrl_wr = 1'b1; ctrl_din = {en, 2'b00, rs, 1'b0};
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_mode(input logic [7:0] m);
        mode_wr = 1'b1; mode_din = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        data_wr = 1'b1; data_din = b;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    // receive one frame starting from the first low cycle; ends at a negedge
    task automatic rx_frame(input int nb, input bit pen, input bit podd, input int stop_t,
                            input logic [7:0] val, input bit last);
        int g;
        int hi;
        logic [7:0] got;
        logic [7:0] m;
        logic pexp;
        g = 0;
        while (txd !== 1'b0 && g < 4000) begin @(negedge clk); g++; end
        if (g >= 4000) begin check(1'b0, "R2 no start bit", 0, 1); return; end
        repeat (OVS / 2) @(negedge clk);
        check(txd == 1'b0, "R2 start bit", int'(txd), 0);
        got = '0;
        for (int i = 0; i < nb; i++) begin
            repeat (OVS) @(negedge clk);
            got[i] = txd;
        end
        m = 8'((1 << nb) - 1);
        check(got == (val & m), "R3 data bits (LSB first, R2)", int'(got), int'(val & m));
        if (pen) begin
            repeat (OVS) @(negedge clk);
            pexp = (^(val & m)) ^ podd;
            check(txd == pexp, "R4 parity bit", int'(txd), int'(pexp));
        end
        repeat (OVS - OVS / 2) @(negedge clk);
        hi = 0;
        while (txd === 1'b1 && hi < 4 * OVS) begin hi++; @(negedge clk); end
        if (!last) check(hi == stop_t + 1, "R5 stop plus gap", hi, stop_t + 1);
        else       check(hi == 4 * OVS, "R5 line high after stop", hi, 4 * OVS);
    endtask

    initial begin
        int nb, st;
        bit pen, podd;
        logic [7:0] m, b0;
        logic [2:0] pb;
        bit stayed;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 idle line", int'(txd), 1);
        check(status_o == 12'h008, "R1 status", int'(status_o), 8);
        check(ctrl_q == 5'd0, "R1 control", int'(ctrl_q), 0);

        // R8 disabled channel keeps bytes queued
        wr_mode(8'h20);
        push(8'h3C);
        push(8'hC3);
        stayed = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed = 1'b0;
        end
        check(stayed, "R8 no frame while disabled", int'(stayed), 1);
        check(status_o[11] == 1'b0, "R8 not busy", int'(status_o[11]), 0);
        check(status_o[3] == 1'b0, "R8 bytes kept", int'(status_o[3]), 0);

        // R7 busy with empty fifo
        wr_ctrl(1'b1, 1'b0);
        rx_frame(8, 1'b0, 1'b0, OVS, 8'h3C, 1'b0);
        check(status_o[3] == 1'b1, "R7 fifo empty in last frame", int'(status_o[3]), 1);
        check(status_o[11] == 1'b1, "R7 busy in last frame", int'(status_o[11]), 1);
        rx_frame(8, 1'b0, 1'b0, OVS, 8'hC3, 1'b1);
        check(status_o[11] == 1'b0, "R7 busy clears", int'(status_o[11]), 0);

        // R6 overfill then drain
        wr_ctrl(1'b0, 1'b0);
        for (int k = 0; k < DEPTH + 2; k++) push(8'(8'h11 * (k + 1)));
        check(status_o[4] == 1'b1, "R6 full flag", int'(status_o[4]), 1);
        check(status_o[3] == 1'b0, "R6 empty flag low", int'(status_o[3]), 0);
        wr_ctrl(1'b1, 1'b0);
        for (int k = 0; k < DEPTH; k++)
            rx_frame(8, 1'b0, 1'b0, OVS, 8'(8'h11 * (k + 1)), k == DEPTH - 1);
        check(status_o[3] == 1'b1, "R6 dropped writes not sent", int'(status_o[3]), 1);

        // R9 logic reset with queued bytes
        wr_ctrl(1'b0, 1'b0);
        push(8'hA1); push(8'hA2); push(8'hA3);
        wr_ctrl(1'b0, 1'b1);
        check(ctrl_q == 5'b00010, "R9 reset bit set", int'(ctrl_q), 2);
        @(negedge clk);
        check(ctrl_q == 5'd0, "R9 reset bit self-clears", int'(ctrl_q), 0);
        check(status_o == 12'h008, "R9 fifo emptied", int'(status_o), 8);
        wr_ctrl(1'b1, 1'b0);
        stayed = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed = 1'b0;
        end
        check(stayed, "R9 nothing left to send", int'(stayed), 1);

        // R9 logic reset mid-frame
        push(8'h00);
        repeat (6) @(negedge clk);
        check(txd == 1'b0, "R9 frame in flight", int'(txd), 0);
        wr_ctrl(1'b1, 1'b1);
        @(negedge clk);
        check(txd == 1'b1, "R9 line high after reset", int'(txd), 1);
        check(status_o[11] == 1'b0, "R9 busy cleared", int'(status_o[11]), 0);

        // R10 stalled tick
        push(8'hFF);
        while (txd !== 1'b0) @(negedge clk);
        tick = 1'b0;
        stayed = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (txd !== 1'b0) stayed = 1'b0;
        end
        check(stayed, "R10 start bit held without tick", int'(stayed), 1);
        check(status_o[11] == 1'b1, "R10 still busy", int'(status_o[11]), 1);
        tick = 1'b1;
        wr_ctrl(1'b0, 1'b1);
        @(negedge clk);

        // R2..R5 sweep over all mode-word combinations
        for (int lc = 0; lc < 4; lc++) begin
            for (int pc = 0; pc < 4; pc++) begin
                for (int sc = 0; sc < 4; sc++) begin
                    case (pc)
                        0: pb = 3'b000;
                        1: pb = 3'b001;
                        2: pb = 3'b100;
                        default: pb = 3'b010;
                    endcase
                    m    = {2'(sc), pb, 2'(lc), 1'b0};
                    nb   = (lc == 2) ? 7 : (lc == 3) ? 6 : 8;
                    pen  = (pc != 2);
                    podd = (pc == 1);
                    st   = (sc == 0) ? OVS : (sc == 1) ? OVS + OVS / 2 : 2 * OVS;
                    b0   = 8'(lc * 61 + pc * 23 + sc * 7 + 8'h5A);
                    wr_ctrl(1'b0, 1'b0);
                    wr_mode(m);
                    push(b0);
                    push(~b0);
                    wr_ctrl(1'b1, 1'b0);
                    rx_frame(nb, pen, podd, st, b0, 1'b0);
                    rx_frame(nb, pen, podd, st, ~b0, 1'b1);
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule